// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to eight single-cycle interrupt request pulses into per-source pending flags. Each flag is gated by its own bit in an enable register and, for the whole controller, by one global enable bit. At each instruction boundary the CPU sequencer marks, the controller looks at the eligible sources and picks the lowest-numbered one. It then raises a request toward the CPU, together with a vector address at a fixed two-byte slot.

The CPU answers with a one-cycle acknowledge pulse. That pulse carries no source number: the controller clears the source whose vector it is presenting. On the same edge it clears the global enable, so the service routine runs with interrupts blocked. Software can reopen them with a register write, which allows nesting. Stacking of program counter and flags, the call and jump cycles, and the routine itself belong to the sequencer, not to this block.

Source 0 stands for reset and is always enabled, whatever its enable bit holds. Source 5 is a spare input.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, `cpu_req` is 0, `cpu_vec` is 0, all pending flags are clear, and both the enable register and the global enable are 0.
- R2: A 1 on `irq_pulse[i]` sets pending flag i at that clock edge. The flag stays set until source i is acknowledged.
- R3: Among eligible sources, the lowest index wins. The vector presented is the index times two, so source i gives address 2*i (0x00, 0x02, ... 0x0E).
- R4: Selection happens only at a rising edge where `insn_end` is 1 and `cpu_req` is 0. It uses the pending flags as registered before that edge. `cpu_req` rises only if the global enable was 1 and some eligible source was pending; it reads 1 in the cycle after that edge.
- R5: A pending source whose enable bit (bit i of the register written by `en_we`/`en_wdata`) is 0 is not selected but stays pending. It becomes selectable at the first boundary after the bit is set.
- R6: Source 0 is eligible whatever bit 0 of the enable register holds.
- R7: While `cpu_req` is 1 and no acknowledge arrives, `cpu_req` stays 1 and `cpu_vec` is unchanged. Further boundaries are ignored.
- R8: `cpu_ack` high while `cpu_req` is 1 clears, at that edge, `cpu_req`, the global enable and the pending flag of the presented source. `cpu_ack` while `cpu_req` is 0 has no effect.
- R9: If `irq_pulse[i]` is 1 in the same cycle as the acknowledge that clears source i, the flag stays set.
- R10: `gie_we` loads the global enable from `gie_wdata`. When it coincides with an accepted acknowledge, the clear wins.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse | input | N_SRC | One request pulse input per source |
| en_we | input | 1 | Write strobe for the per-source enable register |
| en_wdata | input | N_SRC | New per-source enable bits |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| insn_end | input | 1 | High on the last clock of each instruction |
| cpu_req | output | 1 | Interrupt request toward the CPU sequencer |
| cpu_vec | output | VEC_W | Vector address of the presented source |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |

## Verification
The hardest case to reach from the ports is an acknowledge that meets a new pulse from the same source on the same edge. The flag is not visible, so the bench gets there in two steps. A directed step fires the pulse exactly in the acknowledge cycle, then rewrites the global enable and strobes a boundary; the same vector must come back. Masked-but-pending sources and the acknowledge/enable-write collision are reached the same way. Random traffic then mixes sparse pulses, enable writes, boundaries and acknowledges, and compares against a cycle model in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Slot address of a source: index shifted by the slot-size exponent.
  function automatic int unsigned slot_addr(input int unsigned idx,
                                            input int unsigned shift);
    return idx << shift;
  endfunction
endpackage

// File: rtl/irqc_pending_bank.sv
module irqc_pending_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else if (set_i[g]) pend_q[g] <= 1'b1;
      else if (clr_i[g]) pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R2
  no_silent_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |=> ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs #(
  parameter int          N_SRC   = 8,
  parameter logic [7:0]  ALWAYS_ON = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             gie_we,
  input  logic             gie_wdata,
  input  logic             ack_take,
  output logic [N_SRC-1:0] en_eff_o,
  output logic             gie_o
);
  logic [N_SRC-1:0] en_q;
  logic             gie_q;
  logic [N_SRC-1:0] force_on;

  for (genvar g = 0; g < N_SRC; g++) begin : g_force
    if (g < 8) begin : g_lo
      assign force_on[g] = ALWAYS_ON[g];
    end else begin : g_hi
      assign force_on[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      if (ack_take) gie_q <= 1'b0;
      else if (gie_we) gie_q <= gie_wdata;
    end
  end

  assign en_eff_o = en_q | force_on;
  assign gie_o    = gie_q;

  // R10
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> !gie_q);
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic [N_SRC-1:0] grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N_SRC:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign grant_o[g]   = elig_i[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | elig_i[g];
  end

  assign any_o = blocked[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
  end

  // R3
  one_grant_chk: assert final ($onehot0(grant_o));
  // R3
  lowest_wins_chk: assert final (!any_o || elig_i[idx_o]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int         N_SRC      = 8,
  parameter int         VEC_W      = 8,
  parameter int         SLOT_SHIFT = 1,
  parameter logic [7:0] ALWAYS_ON  = 8'h01,
  localparam int        IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_pulse,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             gie_we,
  input  logic             gie_wdata,
  input  logic             insn_end,
  output logic             cpu_req,
  output logic [VEC_W-1:0] cpu_vec,
  input  logic             cpu_ack
);
  import irqc_pkg::*;

  logic [N_SRC-1:0] pend, en_eff, elig, grant, sel_q, clr;
  logic [IDX_W-1:0] win_idx;
  logic             win_any, gie, ack_take, launch;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  assign ack_take = cpu_ack & req_q;
  assign clr      = ack_take ? sel_q : '0;
  assign elig     = pend & en_eff;
  assign launch   = insn_end & ~req_q & gie & win_any;

  irqc_pending_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(irq_pulse), .clr_i(clr), .pend_o(pend));

  irqc_enable_regs #(.N_SRC(N_SRC), .ALWAYS_ON(ALWAYS_ON)) u_en (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .ack_take(ack_take),
    .en_eff_o(en_eff), .gie_o(gie));

  irqc_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .elig_i(elig), .grant_o(grant), .idx_o(win_idx), .any_o(win_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
      sel_q <= '0;
    end else if (ack_take) begin
      req_q <= 1'b0;
    end else if (launch) begin
      req_q <= 1'b1;
      vec_q <= VEC_W'(slot_addr(32'(win_idx), SLOT_SHIFT));
      sel_q <= grant;
    end
  end

  assign cpu_req = req_q;
  assign cpu_vec = vec_q;

  // R7
  hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ack) |=> (cpu_req && $stable(cpu_vec)));

  // R8
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ack) |=> !cpu_req);

  // R4
  rise_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_req) |-> ($past(insn_end) && $past(gie)));

  // R8
  clear_target_chk: assert property (@(posedge clk) disable iff (rst)
    ack_take |-> $onehot(sel_q));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_pulse = '0;
  logic en_we = 0, gie_we = 0, gie_wdata = 0, insn_end = 0, cpu_ack = 0;
  logic [N-1:0] en_wdata = '0;
  logic cpu_req;
  logic [7:0] cpu_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [N-1:0] m_pend, m_en;
  logic m_gie, m_req;
  int   m_sel;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .en_we(en_we),
    .en_wdata(en_wdata), .gie_we(gie_we), .gie_wdata(gie_wdata),
    .insn_end(insn_end), .cpu_req(cpu_req), .cpu_vec(cpu_vec),
    .cpu_ack(cpu_ack));

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_vec(input int s);
    return 8'(s * 2);
  endfunction

  task automatic model_step();
    logic take;
    logic [N-1:0] clr, elig;
    take = cpu_ack & m_req;
    clr  = take ? (N'(1) << m_sel) : '0;
    elig = m_pend & (m_en | N'(1));
    if (take) m_req = 1'b0;
    else if (!m_req && insn_end && m_gie && (elig != 0)) begin
      m_req = 1'b1;
      m_sel = lowest(elig);
    end
    m_pend = (m_pend & ~clr) | irq_pulse;
    if (en_we) m_en = en_wdata;
    if (take) m_gie = 1'b0;
    else if (gie_we) m_gie = gie_wdata;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (cpu_req !== m_req) begin
      errors++;
      $display("FAIL %s req actual %0b expected %0b", tag, cpu_req, m_req);
    end
    if (m_req) begin
      checks++;
      if (cpu_vec !== exp_vec(m_sel)) begin
        errors++;
        $display("FAIL %s vec actual %0h expected %0h", tag, cpu_vec, exp_vec(m_sel));
      end
    end
  endtask

  task automatic cyc(input string tag, input logic [N-1:0] irq,
                     input logic ewe, input logic [N-1:0] ed,
                     input logic gwe, input logic gd,
                     input logic ins, input logic ack);
    irq_pulse = irq; en_we = ewe; en_wdata = ed;
    gie_we = gwe; gie_wdata = gd; insn_end = ins; cpu_ack = ack;
    @(posedge clk);
    model_step();
    @(negedge clk);
    irq_pulse = '0; en_we = 0; gie_we = 0; insn_end = 0; cpu_ack = 0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, '0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pend = '0; m_en = '0; m_gie = 0; m_req = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    checks++;
    if (cpu_req !== 1'b0 || cpu_vec !== 8'h00) begin
      errors++;
      $display("FAIL R1 req/vec actual %0b/%0h expected 0/00", cpu_req, cpu_vec);
    end
    cyc("R1", '0, 0, '0, 0, 0, 1, 0);

    // R6: source 0 with enable register all zero
    cyc("R6", 8'h01, 0, '0, 0, 0, 0, 0);
    cyc("R6", '0, 0, '0, 0, 0, 1, 0);
    cyc("R6", '0, 0, '0, 1, 1, 0, 0);
    cyc("R6", '0, 0, '0, 0, 0, 1, 0);
    idle("R6");
    cyc("R8", '0, 0, '0, 0, 0, 0, 1);

    // R5: masked source stays pending
    cyc("R5", 8'h08, 0, '0, 1, 1, 0, 0);
    cyc("R5", '0, 0, '0, 0, 0, 1, 0);
    idle("R5");
    cyc("R5", '0, 1, 8'h08, 0, 0, 0, 0);
    cyc("R5", '0, 0, '0, 0, 0, 1, 0);
    cyc("R7", '0, 0, '0, 0, 0, 1, 0);
    cyc("R7", 8'h01, 0, '0, 0, 0, 0, 0);
    cyc("R8", '0, 0, '0, 0, 0, 0, 1);
    cyc("R8", '0, 0, '0, 0, 0, 0, 1);

    // R3: priority among 7,4,2 and pending 0
    cyc("R3", 8'h94, 1, 8'hFF, 1, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc("R3", '0, 0, '0, 0, 0, 1, 0);
      cyc("R3", '0, 0, '0, 0, 0, 0, 1);
      cyc("R3", '0, 0, '0, 1, 1, 0, 0);
    end
    cyc("R3", '0, 0, '0, 0, 0, 1, 0);

    // R9: new pulse during acknowledge of the same source
    cyc("R9", 8'h04, 0, '0, 0, 0, 0, 0);
    cyc("R9", '0, 0, '0, 0, 0, 1, 0);
    cyc("R9", 8'h04, 0, '0, 0, 0, 0, 1);
    cyc("R9", '0, 0, '0, 1, 1, 0, 0);
    cyc("R9", '0, 0, '0, 0, 0, 1, 0);

    // R10: enable write colliding with acknowledge
    cyc("R10", 8'h40, 0, '0, 1, 1, 0, 1);
    cyc("R10", '0, 0, '0, 0, 0, 1, 0);
    idle("R10");
    cyc("R10", '0, 0, '0, 1, 1, 0, 0);

    // R4: pulse and boundary on the same edge
    cyc("R4", '0, 0, '0, 0, 0, 1, 0);
    cyc("R4", '0, 0, '0, 0, 0, 0, 1);
    cyc("R4", '0, 0, '0, 1, 1, 0, 0);
    cyc("R4", 8'h20, 0, '0, 0, 0, 1, 0);
    idle("R4");
    cyc("R4", '0, 0, '0, 0, 0, 1, 0);
    cyc("R2", '0, 0, '0, 0, 0, 0, 1);

    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] irq, ed;
      logic ewe, gwe, gd, ins, ack;
      irq = (($urandom % 6) == 0) ? N'(1) << ($urandom % N) : '0;
      ewe = (($urandom % 25) == 0);
      ed  = N'($urandom);
      gwe = (($urandom % 5) == 0);
      gd  = (($urandom % 4) != 0);
      ins = (($urandom % 3) == 0);
      ack = (($urandom % 3) == 0);
      cyc("R2", irq, ewe, ed, gwe, gd, ins, ack);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule